// File: doc/BRIEF.md
# Strobe-Gated Round-Robin Index Arbiter

This block shares one resource among a parameterised number of requesters. Each cycle it sees a request vector, with one bit per requester, and a single advance strobe. It holds the current owner as a binary index. When the strobe is high on a clock edge and at least one request bit is set, the index moves to the next active requester found by counting upward from the current owner and wrapping at the requester count. When the strobe is low, the index does not change.

The owner keeps the grant on a strobe only when no other requester is active. The search starts one place above the current owner, so a busy requester cannot hold the resource while others wait. Logic downstream uses the index directly as a multiplexer select. The requester count does not have to be a power of two.

Top module: `rr_index_arbiter`

## Requirements
- R1: `grant_idx` is an unsigned binary requester number of ceil(log2 NUM_REQ) bits (at least 1), and its value is always below NUM_REQ.
- R2: While `rst_n` is low, and in the first cycle after it rises, `grant_idx` is 0.
- R3: On a rising clock edge with `advance` low, `grant_idx` keeps its value, whatever `req_vec` holds.
- R4: On a rising clock edge with `advance` high and `req_vec` all zero, `grant_idx` keeps its value.
- R5: On a rising clock edge with `advance` high and some bit of `req_vec` set (bit i belongs to requester i), `grant_idx` takes the first index j with `req_vec[j]` set, searching j = g+1, g+2, ... modulo NUM_REQ from the present grant g. The new value is visible after that edge.
- R6: If the only set bit of `req_vec` is the one at the present grant, a strobe leaves `grant_idx` unchanged.
- R7: After any edge on which `advance` was high and `req_vec` was nonzero, the bit of that `req_vec` at the new `grant_idx` was set.
- R8: NUM_REQ is a parameter of at least 2. Counts that are not powers of two wrap correctly, so the index moves from NUM_REQ-1 back to 0.
- R9: With NUM_REQ = 8, starting from grant 0, and with `req_vec` = 8'b10001000 held and `advance` high, the grant goes 3, 7, 3 on successive edges. Changing `req_vec` to 8'b00000001 then gives 0 on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vec | input | NUM_REQ | One request bit per requester |
| advance | input | 1 | Strobe that allows the grant to move on this edge |
| grant_idx | output | ceil(log2 NUM_REQ) | Binary index of the granted requester |

## Verification
Two cases are hard to reach with dense random requests. The first is a strobe when the present owner is the only active requester. The second is a wrap from the top index back to a low one when the vector is sparse. Dense vectors almost never produce either. The stimulus therefore ANDs random words together to get sparse vectors, adds directed single-bit vectors aimed at the current owner, and runs a second instance with five requesters so that the wrap does not come from natural overflow.

// File: rtl/rr_arb_pkg.sv
`timescale 1ns/1ps
package rr_arb_pkg;

   // Index width for a requester count; never below one bit.
   function automatic int unsigned idx_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

   function automatic bit is_pow2(input int unsigned n);
      return (n != 0) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/rr_rotate_right.sv
`timescale 1ns/1ps
module rr_rotate_right
   import rr_arb_pkg::*;
#(
   parameter int unsigned WIDTH = 8,
   localparam int unsigned SH_W = idx_width(WIDTH)
) (
   input  logic [WIDTH-1:0] vec_in,
   input  logic [SH_W-1:0]  amount,
   output logic [WIDTH-1:0] vec_out
);

   logic [2*WIDTH-1:0] doubled;

   assign doubled = {vec_in, vec_in};
   assign vec_out = WIDTH'(doubled >> amount);

endmodule

// File: rtl/rr_lowest_set.sv
`timescale 1ns/1ps
module rr_lowest_set
   import rr_arb_pkg::*;
#(
   parameter int unsigned WIDTH = 8,
   localparam int unsigned IW = idx_width(WIDTH)
) (
   input  logic [WIDTH-1:0] vec,
   output logic [IW-1:0]    idx,
   output logic             found
);

   always_comb begin
      idx = '0;
      for (int i = WIDTH - 1; i >= 0; i--) begin
         if (vec[i]) idx = IW'(i);
      end
   end

   assign found = |vec;

   // R5: the offset picked is a set bit with nothing set below it
   always_comb begin
      if (found) begin
         a_r5_offset_is_set: assert (vec[idx]);
         a_r5_offset_is_lowest: assert ((vec & ((WIDTH'(1) << idx) - WIDTH'(1))) == '0);
      end
   end

endmodule

// File: rtl/rr_wrap_add.sv
`timescale 1ns/1ps
module rr_wrap_add
   import rr_arb_pkg::*;
#(
   parameter int unsigned MODULUS = 8,
   localparam int unsigned W = idx_width(MODULUS)
) (
   input  logic [W-1:0] lhs,
   input  logic [W-1:0] rhs,
   output logic [W-1:0] sum
);

   generate
      if (is_pow2(MODULUS)) begin : g_pow2
         // natural overflow of a W-bit adder is the modulo
         assign sum = lhs + rhs;
      end else begin : g_cmp
         localparam logic [W:0] MOD_V = (W+1)'(MODULUS);
         logic [W:0] raw;
         assign raw = {1'b0, lhs} + {1'b0, rhs};
         assign sum = (raw >= MOD_V) ? W'(raw - MOD_V) : raw[W-1:0];
      end
   endgenerate

endmodule

// File: rtl/rr_index_arbiter.sv
`timescale 1ns/1ps
module rr_index_arbiter
   import rr_arb_pkg::*;
#(
   parameter int unsigned NUM_REQ = 8,
   localparam int unsigned IDX_W = idx_width(NUM_REQ)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_REQ-1:0] req_vec,
   input  logic               advance,
   output logic [IDX_W-1:0]   grant_idx
);

   localparam logic [IDX_W:0] REQ_CNT = (IDX_W+1)'(NUM_REQ);

   generate
      if (NUM_REQ < 2) begin : g_bad_count
         $error("rr_index_arbiter: NUM_REQ must be at least 2 (R8)");
      end
   endgenerate

   logic [IDX_W-1:0]   grant_q;
   logic [IDX_W-1:0]   start_idx;
   logic [IDX_W-1:0]   offset_idx;
   logic [IDX_W-1:0]   next_idx;
   logic [NUM_REQ-1:0] rotated;
   logic               any_req;

   // search begins one place above the holder (R5, R6)
   rr_wrap_add #(.MODULUS(NUM_REQ)) u_start (
      .lhs (grant_q),
      .rhs (IDX_W'(1)),
      .sum (start_idx)
   );

   rr_rotate_right #(.WIDTH(NUM_REQ)) u_rot (
      .vec_in  (req_vec),
      .amount  (start_idx),
      .vec_out (rotated)
   );

   rr_lowest_set #(.WIDTH(NUM_REQ)) u_find (
      .vec   (rotated),
      .idx   (offset_idx),
      .found (any_req)
   );

   rr_wrap_add #(.MODULUS(NUM_REQ)) u_next (
      .lhs (start_idx),
      .rhs (offset_idx),
      .sum (next_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 grant_q <= '0;
      else if (advance && any_req) grant_q <= next_idx;
   end

   assign grant_idx = grant_q;

   // ---------------- assertions ----------------
   logic [NUM_REQ-1:0] req_prev;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_prev <= '0;
      else        req_prev <= req_vec;
   end

   a_r1_index_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      {1'b0, grant_idx} < REQ_CNT);

   a_r3_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !advance |=> $stable(grant_idx));

   a_r4_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && req_vec == '0) |=> $stable(grant_idx));

   a_r5_leaves_holder: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && |(req_vec & ~(NUM_REQ'(1) << grant_idx))) |=> !$stable(grant_idx));

   a_r6_sole_holder_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && req_vec == (NUM_REQ'(1) << grant_idx)) |=> $stable(grant_idx));

   a_r7_grant_was_requested: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && req_vec != '0) |=> req_prev[grant_idx]);

endmodule

// File: tb/rr_index_arbiter_test.sv
`timescale 1ns/1ps
module rr_index_arbiter_test;
   import rr_arb_pkg::*;

   localparam int unsigned NA = 8;
   localparam int unsigned NB = 5;
   localparam int unsigned WA = idx_width(NA);
   localparam int unsigned WB = idx_width(NB);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NA-1:0] req = '0;
   logic          adv = 1'b0;
   logic [WA-1:0] grant_a;
   logic [WB-1:0] grant_b;

   int n_checks = 0;
   int n_errors = 0;
   int model_a = 0;
   int model_b = 0;
   bit done = 0;

   always #2 clk = ~clk;

   rr_index_arbiter #(.NUM_REQ(NA)) uut (
      .clk (clk), .rst_n (rst_n), .req_vec (req), .advance (adv), .grant_idx (grant_a)
   );

   rr_index_arbiter #(.NUM_REQ(NB)) uut_odd (
      .clk (clk), .rst_n (rst_n), .req_vec (req[NB-1:0]), .advance (adv), .grant_idx (grant_b)
   );

   function automatic int ref_next(int cur, logic [NA-1:0] r, int n);
      for (int k = 1; k <= n; k++) begin
         int c;
         c = (cur + k) % n;
         if (r[c]) return c;
      end
      return cur;
   endfunction

   function automatic logic [NA-1:0] masked(logic [NA-1:0] r, int n);
      return r & NA'((1 << n) - 1);
   endfunction

   function automatic string classify(logic a, logic [NA-1:0] r, int cur);
      if (!a) return "R3";
      if (r == '0) return "R4";
      if (r == NA'(1 << cur)) return "R6";
      return "R5";
   endfunction

   task automatic check(string tag, int actual, int expected);
      n_checks++;
      if (actual != expected) begin
         n_errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, actual, expected, $time);
      end
   endtask

   // one edge with the present inputs, then compare both instances
   task automatic tick();
      logic [NA-1:0] ra, rb;
      int ea, eb;
      string ta, tb;
      ra = masked(req, NA);
      rb = masked(req, NB);
      ta = classify(adv, ra, model_a);
      tb = classify(adv, rb, model_b);
      ea = (adv && ra != '0) ? ref_next(model_a, ra, NA) : model_a;
      eb = (adv && rb != '0) ? ref_next(model_b, rb, NB) : model_b;
      @(posedge clk);
      #1;
      check(ta, int'(grant_a), ea);
      check({tb, " R8"}, int'(grant_b), eb);
      check("R1", int'(grant_b < NB), 1);
      if (adv && rb != '0) check("R7", int'(rb[grant_b]), 1);
      model_a = ea;
      model_b = eb;
   endtask

   initial begin
      void'($urandom(32'h1234_5678));
      repeat (3) @(posedge clk);
      #1;
      check("R2", int'(grant_a), 0);
      rst_n = 1'b1;
      #1;
      check("R2", int'(grant_b), 0);

      // R9 directed sequence
      req = 8'b1000_1000;
      adv = 1'b1;
      tick(); check("R9", int'(grant_a), 3);
      tick(); check("R9", int'(grant_a), 7);
      tick(); check("R9", int'(grant_a), 3);
      req = 8'b0000_0001;
      tick(); check("R9", int'(grant_a), 0);

      // R6 sole holder, R4 idle, R3 no strobe
      tick(); check("R6", int'(grant_a), 0);
      req = '0;
      tick(); check("R4", int'(grant_a), 0);
      adv = 1'b0;
      req = 8'hFF;
      tick(); check("R3", int'(grant_a), 0);
      req = 8'b0001_0000;
      adv = 1'b1;
      tick(); check("R8", int'(grant_b), 4);
      req = 8'b0000_0010;
      tick(); check("R8", int'(grant_b), 1);

      // random phase
      for (int i = 0; i < 4000; i++) begin
         logic [31:0] r;
         r = $urandom;
         adv = ($urandom % 4) != 0;
         case ($urandom % 4)
            0: req = NA'(r & (r >> 8) & (r >> 16));
            1: req = NA'(1 << model_a);
            2: req = NA'(1 << model_b);
            default: req = NA'(r);
         endcase
         tick();
      end

      // R2 again with asynchronous reset mid-run
      adv = 1'b1;
      req = 8'b0100_0000;
      tick();
      rst_n = 1'b0;
      #1;
      check("R2", int'(grant_a), 0);
      check("R2", int'(grant_b), 0);
      @(posedge clk);
      #1;
      rst_n = 1'b1;
      model_a = 0;
      model_b = 0;
      adv = 1'b0;
      #1;
      check("R2", int'(grant_a), 0);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         n_errors++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

endmodule